// File: doc/BRIEF.md
# PHY Register Indirect Access Sequencer

This block lets on-chip logic read and write the 16-bit registers of an Ethernet PHY that can only be reached through a handful of byte-wide indirect registers on the MAC side. Those indirect registers hold the PHY register number, a command byte, two write-data bytes, two read-data bytes and a status byte with a busy flag. A caller hands over one request: a PHY register number, a direction and, for a write, a 16-bit value. The sequencer turns it into an ordered list of single-byte control-register operations. Each operation goes out to a downstream command sequencer, which owns the serial transport and the bank selection. When the PHY is finished, the sequencer returns one response carrying the 16-bit read data and an error flag.

A read loads the register number and then pulses the read-command bit, by setting it and then clearing it. It then polls the busy flag and fetches the low byte of the result before the high byte. A write has no command bit. Loading the high data byte starts the PHY transfer, and the sequencer then polls busy until it clears. If busy stays set for a configurable number of polls, the wait is abandoned and the response is flagged as an error. Only one request is handled at a time.

The request side is valid/ready. `req_ready` is high only while the sequencer is idle, so a caller holds `req_valid` and its fields until they are taken. The response side is valid/ready too. `rsp_valid` and its data stay constant until `rsp_ready` is seen. Each downstream operation is presented with `cmd_valid` and held unchanged until `cmd_ready`. The downstream side then reports completion with a one-cycle `cmd_done`, carrying the byte read. A new operation is never offered before the previous one has completed.

Top module: `phy_indirect_engine`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `cmd_valid` is 0.
- R2: A read issues, in order: a write of the PHY register number to bank 2 register 0x14, a write of 0x01 to bank 2 register 0x12 (read command, bit 0), and a write of 0x00 to bank 2 register 0x12. Then come the status polls, then a read of bank 2 register 0x18 (low byte), then a read of bank 2 register 0x19 (high byte).
- R3: A write issues, in order: a write of the PHY register number to bank 2 register 0x14, a write of data bits 7:0 to bank 2 register 0x16, and a write of data bits 15:8 to bank 2 register 0x17. Then come the status polls. No command-register write is issued.
- R4: A status poll is a read of bank 3 register 0x0A. `cmd_write` is 1 for a write and 0 for a read. `cmd_dummy`, which asks the downstream to discard a leading dummy byte, is 1 for every read the block issues and 0 for every write.
- R5: A poll is repeated while bit 0 (busy) of the returned status byte is 1. The sequence moves on after the first poll that returns bit 0 clear.
- R6: The read response data equals (high byte << 8) | low byte, and `rsp_error` is 0.
- R7: If POLL_LIMIT consecutive polls in one request all return busy, no further operations are issued. The response has `rsp_error` = 1 and `rsp_rdata` = 0.
- R8: From the cycle a request is accepted until its response is accepted, `req_ready` is 0.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_rdata` and `rsp_error` hold their values.
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid` and all operation fields hold. `cmd_valid` is never 1 between an accepted operation and its `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_write | input | 1 | 1 = write PHY register, 0 = read |
| req_addr | input | ADDR_W | PHY register number |
| req_wdata | input | 16 | Value to write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 16 | Read result (0 for writes and errors) |
| rsp_error | output | 1 | Busy wait abandoned at the poll limit |
| cmd_valid | output | 1 | Control-register operation offered |
| cmd_ready | input | 1 | Operation taken by downstream |
| cmd_write | output | 1 | 1 = write control register, 0 = read |
| cmd_bank | output | 2 | Register bank of the operation |
| cmd_reg | output | 5 | Register offset within the bank |
| cmd_wdata | output | 8 | Byte to write |
| cmd_dummy | output | 1 | Discard leading dummy byte on read |
| cmd_done | input | 1 | Operation complete (one-cycle pulse) |
| cmd_rdata | input | 8 | Byte read, valid with cmd_done |

## Verification
The hardest state to reach from the ports is the abandoned busy wait. It needs a PHY that never finishes, and it needs the poll counter to reach its limit exactly, with no data reads issued afterwards. The bench's downstream model keeps a busy count per transfer, and one special value pins busy on for good. With that setting the expected operation log is exactly three setup writes followed by POLL_LIMIT status reads. The model also withholds `cmd_ready` for a cycle on every operation, so the hold rules are exercised on every step and not only in a dedicated test.

// File: rtl/phyacc_pkg.sv
package phyacc_pkg;
  parameter int BANK_W = 2;
  parameter int REG_W  = 5;
  parameter int BYTE_W = 8;
  parameter int DATA_W = 16;

  // bank/offset pairs decoded by the downstream command sequencer
  parameter logic [BANK_W-1:0] BANK_MIX  = 2'd2;
  parameter logic [BANK_W-1:0] BANK_STAT = 2'd3;
  parameter logic [REG_W-1:0]  R_PADDR   = 5'h14;
  parameter logic [REG_W-1:0]  R_PCMD    = 5'h12;
  parameter logic [REG_W-1:0]  R_WLO     = 5'h16;
  parameter logic [REG_W-1:0]  R_WHI     = 5'h17;
  parameter logic [REG_W-1:0]  R_RLO     = 5'h18;
  parameter logic [REG_W-1:0]  R_RHI     = 5'h19;
  parameter logic [REG_W-1:0]  R_STAT    = 5'h0A;
  parameter int RDCMD_BIT = 0;
  parameter int BUSY_BIT  = 0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_CSET, ST_CCLR, ST_WLO, ST_WHI,
    ST_POLL, ST_RLO, ST_RHI, ST_RESP
  } step_e;

  typedef struct packed {
    logic              wr;
    logic [BANK_W-1:0] bank;
    logic [REG_W-1:0]  rsel;
    logic [BYTE_W-1:0] data;
    logic              dummy;
  } ctl_op_t;
endpackage

// File: rtl/phyacc_opgen.sv
module phyacc_opgen
  import phyacc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  step_e             step,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output ctl_op_t           op
);
  localparam logic [BYTE_W-1:0] RD_PULSE = BYTE_W'(1) << RDCMD_BIT;

  always_comb begin
    op = '0;
    unique case (step)
      ST_ADDR: op = '{wr: 1'b1, bank: BANK_MIX, rsel: R_PADDR,
                      data: BYTE_W'(addr), dummy: 1'b0};
      ST_CSET: op = '{wr: 1'b1, bank: BANK_MIX, rsel: R_PCMD,
                      data: RD_PULSE, dummy: 1'b0};
      ST_CCLR: op = '{wr: 1'b1, bank: BANK_MIX, rsel: R_PCMD,
                      data: '0, dummy: 1'b0};
      ST_WLO:  op = '{wr: 1'b1, bank: BANK_MIX, rsel: R_WLO,
                      data: wdata[BYTE_W-1:0], dummy: 1'b0};
      ST_WHI:  op = '{wr: 1'b1, bank: BANK_MIX, rsel: R_WHI,
                      data: wdata[DATA_W-1:BYTE_W], dummy: 1'b0};
      ST_POLL: op = '{wr: 1'b0, bank: BANK_STAT, rsel: R_STAT,
                      data: '0, dummy: 1'b1};
      ST_RLO:  op = '{wr: 1'b0, bank: BANK_MIX, rsel: R_RLO,
                      data: '0, dummy: 1'b1};
      ST_RHI:  op = '{wr: 1'b0, bank: BANK_MIX, rsel: R_RHI,
                      data: '0, dummy: 1'b1};
      default: op = '0;
    endcase
  end
endmodule

// File: rtl/phyacc_pollcnt.sv
module phyacc_pollcnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == TOP);
endmodule

// File: rtl/phyacc_seq.sv
module phyacc_seq
  import phyacc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_fire,
  input  logic  is_write,
  input  logic  op_fire,
  input  logic  op_done,
  input  logic  stat_busy,
  input  logic  poll_last,
  input  logic  rsp_fire,
  output step_e step,
  output logic  op_pending,
  output logic  poll_clr,
  output logic  poll_inc,
  output logic  cap_lo,
  output logic  cap_hi,
  output logic  set_err
);
  logic  issued;
  logic  done_ok;
  logic  op_step;
  step_e nxt;

  assign op_step    = (step != ST_IDLE) && (step != ST_RESP);
  assign op_pending = op_step && !issued;
  assign done_ok    = op_done && issued;

  assign poll_clr = req_fire;
  assign poll_inc = done_ok && (step == ST_POLL) && stat_busy;
  assign cap_lo   = done_ok && (step == ST_RLO);
  assign cap_hi   = done_ok && (step == ST_RHI);
  assign set_err  = poll_inc && poll_last;

  always_comb begin
    nxt = step;
    unique case (step)
      ST_IDLE: if (req_fire) nxt = ST_ADDR;
      ST_ADDR: if (done_ok) nxt = is_write ? ST_WLO : ST_CSET;
      ST_CSET: if (done_ok) nxt = ST_CCLR;
      ST_CCLR: if (done_ok) nxt = ST_POLL;
      ST_WLO:  if (done_ok) nxt = ST_WHI;
      ST_WHI:  if (done_ok) nxt = ST_POLL;
      ST_POLL: if (done_ok) begin
        if (stat_busy) nxt = poll_last ? ST_RESP : ST_POLL;
        else           nxt = is_write ? ST_RESP : ST_RLO;
      end
      ST_RLO:  if (done_ok) nxt = ST_RHI;
      ST_RHI:  if (done_ok) nxt = ST_RESP;
      ST_RESP: if (rsp_fire) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step   <= ST_IDLE;
      issued <= 1'b0;
    end else begin
      step <= nxt;
      if (done_ok)      issued <= 1'b0;
      else if (op_fire) issued <= 1'b1;
    end
  end
endmodule

// File: rtl/phy_indirect_engine.sv
module phy_indirect_engine
  import phyacc_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int POLL_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_rdata,
  output logic              rsp_error,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [1:0]        cmd_bank,
  output logic [4:0]        cmd_reg,
  output logic [7:0]        cmd_wdata,
  output logic              cmd_dummy,
  input  logic              cmd_done,
  input  logic [7:0]        cmd_rdata
);
  step_e             step;
  ctl_op_t           op;
  logic              op_pending;
  logic              poll_clr, poll_inc, poll_last;
  logic              cap_lo, cap_hi, set_err;
  logic              req_fire, rsp_fire, op_fire;
  logic              t_write;
  logic [ADDR_W-1:0] t_addr;
  logic [DATA_W-1:0] t_wdata;
  logic [BYTE_W-1:0] rd_lo, rd_hi;
  logic              err_q;

  assign req_ready = (step == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign rsp_valid = (step == ST_RESP);
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign cmd_valid = op_pending;
  assign op_fire   = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_write <= 1'b0;
      t_addr  <= '0;
      t_wdata <= '0;
      rd_lo   <= '0;
      rd_hi   <= '0;
      err_q   <= 1'b0;
    end else if (req_fire) begin
      t_write <= req_write;
      t_addr  <= req_addr;
      t_wdata <= req_wdata;
      rd_lo   <= '0;
      rd_hi   <= '0;
      err_q   <= 1'b0;
    end else begin
      if (cap_lo)  rd_lo <= cmd_rdata;
      if (cap_hi)  rd_hi <= cmd_rdata;
      if (set_err) err_q <= 1'b1;
    end
  end

  phyacc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_fire   (req_fire),
    .is_write   (t_write),
    .op_fire    (op_fire),
    .op_done    (cmd_done),
    .stat_busy  (cmd_rdata[BUSY_BIT]),
    .poll_last  (poll_last),
    .rsp_fire   (rsp_fire),
    .step       (step),
    .op_pending (op_pending),
    .poll_clr   (poll_clr),
    .poll_inc   (poll_inc),
    .cap_lo     (cap_lo),
    .cap_hi     (cap_hi),
    .set_err    (set_err)
  );

  phyacc_pollcnt #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (poll_clr),
    .inc   (poll_inc),
    .last  (poll_last)
  );

  phyacc_opgen #(.ADDR_W(ADDR_W)) u_opgen (
    .step  (step),
    .addr  (t_addr),
    .wdata (t_wdata),
    .op    (op)
  );

  assign cmd_write = op.wr;
  assign cmd_bank  = op.bank;
  assign cmd_reg   = op.rsel;
  assign cmd_wdata = op.data;
  assign cmd_dummy = op.dummy;
  assign rsp_rdata = {rd_hi, rd_lo};
  assign rsp_error = err_q;
endmodule

// File: rtl/phyacc_chk.sv
module phyacc_chk
  import phyacc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_rdata,
  input logic        rsp_error,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        cmd_write,
  input logic [1:0]  cmd_bank,
  input logic [4:0]  cmd_reg,
  input logic [7:0]  cmd_wdata,
  input logic        cmd_dummy,
  input logic        cmd_done
);
  logic outst;

  always_ff @(posedge clk) begin
    if (!rst_n)                      outst <= 1'b0;
    else if (cmd_valid && cmd_ready) outst <= 1'b1;
    else if (cmd_done)               outst <= 1'b0;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> req_ready && !rsp_valid && !cmd_valid);

  p_dummy_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_dummy == !cmd_write));

  p_stat_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && cmd_reg == R_STAT) |-> (cmd_bank == BANK_STAT));

  p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_error) |-> (rsp_rdata == 16'h0000));

  p_busy_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || cmd_valid || outst) |-> !req_ready);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable({rsp_rdata, rsp_error}));

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      cmd_valid && $stable({cmd_write, cmd_bank, cmd_reg, cmd_wdata, cmd_dummy}));

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !outst);
endmodule

bind phy_indirect_engine phyacc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_error (rsp_error),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_write (cmd_write),
  .cmd_bank  (cmd_bank),
  .cmd_reg   (cmd_reg),
  .cmd_wdata (cmd_wdata),
  .cmd_dummy (cmd_dummy),
  .cmd_done  (cmd_done)
);

// File: tb/phy_indirect_engine_test.sv
`timescale 1ns/1ps
module phy_indirect_engine_test;
  localparam int LIM = 16;
  localparam logic [7:0] STUCK = 8'hFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_error;
  logic [15:0] rsp_rdata;
  logic        cmd_valid, cmd_write, cmd_dummy;
  logic [1:0]  cmd_bank;
  logic [4:0]  cmd_reg;
  logic [7:0]  cmd_wdata;
  logic        cmd_ready, cmd_done;
  logic [7:0]  cmd_rdata;

  int checks = 0, errors = 0, cycles = 0, hold_viol = 0;
  logic [7:0] busy_cfg = 8'd0;

  always #2.5 clk = ~clk;

  phy_indirect_engine #(.ADDR_W(5), .POLL_LIMIT(LIM)) uut (.*);

  // downstream command sequencer + PHY model
  logic [15:0] phy [32];
  logic [4:0]  m_addr;
  logic [7:0]  m_lo, m_busy;
  logic [15:0] m_rd;
  logic [7:0]  m_resp;
  logic [1:0]  m_delay;
  logic        lg_wr [128];
  logic [1:0]  lg_bank [128];
  logic [4:0]  lg_reg [128];
  logic [7:0]  lg_data [128];
  logic        lg_dum [128];
  int          log_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      cmd_ready <= 1'b0; cmd_done <= 1'b0; cmd_rdata <= '0;
      m_delay <= '0; m_busy <= '0; m_addr <= '0; m_lo <= '0; m_rd <= '0;
      log_n <= 0; m_resp <= '0;
      for (int i = 0; i < 32; i++) phy[i] <= 16'(i * 16'h0101);
    end else begin
      cmd_done <= 1'b0;
      if (m_delay != 0) begin
        m_delay <= m_delay - 1'b1;
        if (m_delay == 2'd1) begin cmd_done <= 1'b1; cmd_rdata <= m_resp; end
      end
      if (cmd_valid && cmd_ready) begin
        lg_wr[log_n % 128] <= cmd_write; lg_bank[log_n % 128] <= cmd_bank;
        lg_reg[log_n % 128] <= cmd_reg; lg_data[log_n % 128] <= cmd_wdata;
        lg_dum[log_n % 128] <= cmd_dummy;
        log_n <= log_n + 1;
        cmd_ready <= 1'b0; m_delay <= 2'd2; m_resp <= 8'h00;
        if (cmd_write) begin
          case (cmd_reg)
            5'h14: m_addr <= cmd_wdata[4:0];
            5'h12: if (cmd_wdata[0]) begin m_rd <= phy[m_addr]; m_busy <= busy_cfg; end
            5'h16: m_lo <= cmd_wdata;
            5'h17: begin phy[m_addr] <= {cmd_wdata, m_lo}; m_busy <= busy_cfg; end
            default: ;
          endcase
        end else begin
          case (cmd_reg)
            5'h0A: begin
              m_resp <= (m_busy != 0) ? 8'h01 : 8'h00;
              if (m_busy != 0 && m_busy != STUCK) m_busy <= m_busy - 1'b1;
            end
            5'h18: m_resp <= m_rd[7:0];
            5'h19: m_resp <= m_rd[15:8];
            default: ;
          endcase
        end
      end else if (cmd_valid && !cmd_ready && m_delay == 0 && !cmd_done) begin
        cmd_ready <= 1'b1;
      end
    end
  end

  // R10: an offered operation may not be withdrawn before it is taken
  logic prev_wait = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_wait && !cmd_valid) hold_viol++;
    prev_wait = rst_n && cmd_valid && !cmd_ready;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_op(input int idx, input logic wr, input logic [1:0] bank,
                        input logic [4:0] rsel, input logic [7:0] data, input string req);
    check(lg_wr[idx] == wr && lg_bank[idx] == bank && lg_reg[idx] == rsel &&
          lg_dum[idx] == !wr && (!wr || lg_data[idx] == data), req,
          {23'd0, lg_wr[idx], lg_bank[idx], lg_reg[idx]}, {23'd0, wr, bank, rsel});
  endtask

  int base;

  task automatic run_req(input logic wr, input logic [4:0] a, input logic [15:0] d,
                         input int hold, output logic [15:0] rd, output logic er);
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    base = log_n;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8", int'(req_ready), 0);
    guard = 0;
    while (!rsp_valid && guard < 5000) begin @(negedge clk); guard++; end
    check(rsp_valid == 1'b1, "R8", int'(rsp_valid), 1);
    check(req_ready == 1'b0, "R8", int'(req_ready), 0);
    rd = rsp_rdata; er = rsp_error;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_rdata == rd && rsp_error == er, "R9",
            int'(rsp_rdata), int'(rd));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R8", int'(req_ready), 1);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);
    check(cmd_valid == 1'b0, "R1", int'(cmd_valid), 0);
  endtask

  task automatic t_write_busy();
    logic [15:0] rd; logic er;
    busy_cfg = 8'd2;
    run_req(1'b1, 5'h04, 16'hBEEF, 0, rd, er);
    check(log_n - base == 6, "R5", log_n - base, 6);
    chk_op(base + 0, 1'b1, 2'd2, 5'h14, 8'h04, "R3");
    chk_op(base + 1, 1'b1, 2'd2, 5'h16, 8'hEF, "R3");
    chk_op(base + 2, 1'b1, 2'd2, 5'h17, 8'hBE, "R3");
    for (int i = 3; i < 6; i++) chk_op(base + i, 1'b0, 2'd3, 5'h0A, 8'h00, "R4");
    check(er == 1'b0 && rd == 16'h0000, "R3", int'(rd), 0);
  endtask

  task automatic t_read_fast();
    logic [15:0] rd; logic er;
    busy_cfg = 8'd0;
    run_req(1'b0, 5'h04, 16'h0000, 0, rd, er);
    check(rd == 16'hBEEF && er == 1'b0, "R6", int'(rd), 16'hBEEF);
    check(log_n - base == 6, "R2", log_n - base, 6);
    chk_op(base + 0, 1'b1, 2'd2, 5'h14, 8'h04, "R2");
    chk_op(base + 1, 1'b1, 2'd2, 5'h12, 8'h01, "R2");
    chk_op(base + 2, 1'b1, 2'd2, 5'h12, 8'h00, "R2");
    chk_op(base + 3, 1'b0, 2'd3, 5'h0A, 8'h00, "R4");
    chk_op(base + 4, 1'b0, 2'd2, 5'h18, 8'h00, "R2");
    chk_op(base + 5, 1'b0, 2'd2, 5'h19, 8'h00, "R2");
  endtask

  task automatic t_read_slow();
    logic [15:0] rd; logic er;
    busy_cfg = 8'd3;
    run_req(1'b0, 5'h1D, 16'h0000, 0, rd, er);
    check(rd == 16'h1D1D && er == 1'b0, "R6", int'(rd), 16'h1D1D);
    check(log_n - base == 9, "R5", log_n - base, 9);
    for (int i = 3; i < 7; i++) chk_op(base + i, 1'b0, 2'd3, 5'h0A, 8'h00, "R5");
    chk_op(base + 7, 1'b0, 2'd2, 5'h18, 8'h00, "R5");
  endtask

  task automatic t_limit();
    logic [15:0] rd; logic er;
    busy_cfg = STUCK;
    run_req(1'b0, 5'h04, 16'h0000, 0, rd, er);
    check(er == 1'b1, "R7", int'(er), 1);
    check(rd == 16'h0000, "R7", int'(rd), 0);
    check(log_n - base == 3 + LIM, "R7", log_n - base, 3 + LIM);
    chk_op(base + 2 + LIM, 1'b0, 2'd3, 5'h0A, 8'h00, "R7");
  endtask

  task automatic t_hold();
    logic [15:0] rd; logic er;
    busy_cfg = 8'd1;
    run_req(1'b0, 5'h07, 16'h0000, 5, rd, er);
    check(rd == 16'h0707 && er == 1'b0, "R9", int'(rd), 16'h0707);
    check(hold_viol == 0, "R10", hold_viol, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_busy();
    t_read_fast();
    t_read_slow();
    t_limit();
    t_hold();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 50000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule